// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

A purely combinational adder that forms the sum of two unsigned operands and a carry input, returning the sum and a carry output. The default build is 16 bits, split into four 4-bit groups. Inside each group, every carry is written as a flat sum of products over per-bit generate and propagate terms. That keeps the path from any operand bit to any carry at two gate levels.

Each group also reports a group generate and a group propagate. A link stage turns these into the carry entering each group. A parameter picks one of three ways to build the structure:
- lookahead groups under a second-level lookahead unit (the default);
- lookahead groups chained by ripple;
- ripple groups under a lookahead link.

All three styles give the same result. They differ only in gate depth and gate count.

The adder has no clock and no state. It sits in a datapath as a plain function of its inputs, so no valid/ready handshake is needed and there is no reset.

Top module: `lookahead_adder`

## Requirements
- R1: For every input, {carry_out, sum} equals the 17-bit arithmetic value a + b + carry_in.
- R2: When every bit position propagates and carry_in is 1, the carry crosses all four groups. For example, a=16'hFFFF, b=16'h0000, carry_in=1 gives sum=16'h0000 and carry_out=1.
- R3: Propagate is the OR of the two operand bits, and each sum bit is formed as a XOR b XOR carry. So positions where both bits are 1 still yield the correct sum bit. For example, 16'hFFFF + 16'hFFFF + 0 gives sum=16'hFFFE and carry_out=1.
- R4: The carry entering group k (bit k*4) equals the carry out of adding the operands' low k*4 bits with carry_in. For example, 16'h000F + 16'h0001 gives sum=16'h0010.
- R5: The three interconnect styles (parameter LINK = LINK_TWO_LEVEL, LINK_RIPPLE_GROUPS, LINK_RIPPLE_INSIDE) give bit-identical sum and carry_out for every input.
- R6: carry_out is 1 exactly when a + b + carry_in exceeds 16'hFFFF. For example, 16'h8000 + 16'h8000 gives carry_out=1 and sum=16'h0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The adder has no state. A wrong internal carry therefore shows at the ports at once, as a wrong sum bit at the first bit of the affected group. It also flips every higher sum bit that the carry would reach through a chain of propagating positions. The operand patterns are chosen so that a carry must cross a group boundary. Each group's carry-in is also compared directly against the carry of the low-order partial sum. As a result, a fault in the second-level unit is tied to the group it corrupts, not only to the final sum.

// File: rtl/lookahead_pkg.sv
package lookahead_pkg;
  typedef enum logic [1:0] {
    LINK_TWO_LEVEL     = 2'd0,
    LINK_RIPPLE_GROUPS = 2'd1,
    LINK_RIPPLE_INSIDE = 2'd2
  } link_style_e;
endpackage

// File: rtl/carry_sop.sv
// Flat two-level carry network: carry k is the OR over all terms
// (source j AND every propagate above j and below k).
module carry_sop #(
  parameter int N = 4
) (
  input  logic [N-1:0] g,
  input  logic [N-1:0] p,
  input  logic         c0,
  output logic [N:0]   c
);
  always_comb begin
    c = '0;
    c[0] = c0;
    for (int k = 1; k <= N; k++) begin
      for (int j = 0; j <= k; j++) begin
        logic term;
        if (j == 0) term = c0;
        else        term = g[j-1];
        for (int m = j; m < k; m++) term = term & p[m];
        c[k] = c[k] | term;
      end
    end
  end
endmodule

// File: rtl/adder_group.sv
module adder_group #(
  parameter int GROUP  = 4,
  parameter bit RIPPLE = 1'b0
) (
  input  logic [GROUP-1:0] a,
  input  logic [GROUP-1:0] b,
  input  logic             cin,
  output logic [GROUP-1:0] sum,
  output logic             gg,
  output logic             gp
);
  logic [GROUP-1:0] g, p;
  logic [GROUP:0]   c;

  assign g = a & b;
  assign p = a | b;

  generate
    if (RIPPLE) begin : g_ripple
      always_comb begin
        c[0] = cin;
        for (int i = 0; i < GROUP; i++) c[i+1] = g[i] | (p[i] & c[i]);
      end
    end else begin : g_flat
      carry_sop #(.N(GROUP)) u_sop (.g(g), .p(p), .c0(cin), .c(c));
    end
  endgenerate

  // Group generate: flat OR of each generate gated by the propagates above it.
  always_comb begin
    gg = 1'b0;
    for (int j = 0; j < GROUP; j++) begin
      logic term;
      term = g[j];
      for (int m = j + 1; m < GROUP; m++) term = term & p[m];
      gg = gg | term;
    end
  end

  assign gp  = &p;
  // Sum uses XOR of operands, never the OR-based propagate.
  assign sum = a ^ b ^ c[GROUP-1:0];
endmodule

// File: rtl/lookahead_adder.sv
module lookahead_adder
  import lookahead_pkg::*;
#(
  parameter int          WIDTH = 16,
  parameter int          GROUP = 4,
  parameter link_style_e LINK  = LINK_TWO_LEVEL
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);
  localparam int  NGROUP       = WIDTH / GROUP;
  localparam bit  INNER_RIPPLE = (LINK == LINK_RIPPLE_INSIDE);

  logic [NGROUP-1:0] gg, gp;
  logic [NGROUP:0]   gcarry;

  generate
    for (genvar k = 0; k < NGROUP; k++) begin : g_grp
      adder_group #(.GROUP(GROUP), .RIPPLE(INNER_RIPPLE)) u_grp (
        .a   (a[k*GROUP +: GROUP]),
        .b   (b[k*GROUP +: GROUP]),
        .cin (gcarry[k]),
        .sum (sum[k*GROUP +: GROUP]),
        .gg  (gg[k]),
        .gp  (gp[k])
      );
    end

    if (LINK == LINK_RIPPLE_GROUPS) begin : g_link_ripple
      always_comb begin
        gcarry[0] = carry_in;
        for (int k = 0; k < NGROUP; k++)
          gcarry[k+1] = gg[k] | (gp[k] & gcarry[k]);
      end
    end else begin : g_link_sop
      carry_sop #(.N(NGROUP)) u_link (.g(gg), .p(gp), .c0(carry_in), .c(gcarry));
    end
  endgenerate

  assign carry_out = gcarry[NGROUP];
endmodule

// File: rtl/lookahead_adder_chk.sv
module lookahead_adder_chk #(
  parameter int WIDTH  = 16,
  parameter int GROUP  = 4,
  parameter int NGROUP = WIDTH / GROUP
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             carry_in,
  input logic [WIDTH-1:0] sum,
  input logic             carry_out,
  input logic [NGROUP:0]  gcarry
);
  logic [WIDTH:0] ref_total;
  assign ref_total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, carry_in};

  always_comb begin
    p_total_r1: assert ({carry_out, sum} == ref_total)
      else $error("R1 total mismatch");
    p_full_propagate_r2: assert (!((&(a | b)) && carry_in) || carry_out)
      else $error("R2 carry lost across groups");
    p_low_bit_xor_r3: assert (sum[0] == (a[0] ^ b[0] ^ carry_in))
      else $error("R3 bit 0 not xor-formed");
    p_overflow_r6: assert (carry_out == (ref_total > {1'b0, {WIDTH{1'b1}}}))
      else $error("R6 overflow flag wrong");
    for (int k = 1; k < NGROUP; k++) begin
      logic [WIDTH:0] mask, part;
      mask = ({{WIDTH{1'b0}}, 1'b1} << (k * GROUP)) - 1'b1;
      part = ({1'b0, a} & mask) + ({1'b0, b} & mask) + {{WIDTH{1'b0}}, carry_in};
      p_group_carry_r4: assert (gcarry[k] == part[k*GROUP])
        else $error("R4 group carry wrong at group %0d", k);
    end
  end
endmodule

bind lookahead_adder lookahead_adder_chk #(.WIDTH(WIDTH), .GROUP(GROUP)) u_chk (
  .a(a), .b(b), .carry_in(carry_in), .sum(sum), .carry_out(carry_out), .gcarry(gcarry)
);

// File: tb/test_lookahead_adder.sv
`timescale 1ns/1ps
module test_lookahead_adder;
  import lookahead_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] a, b;
  logic        cin;
  logic [15:0] s0, s1, s2;
  logic        c0, c1, c2;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  lookahead_adder #(.LINK(LINK_TWO_LEVEL)) i_lookahead_adder (
    .a(a), .b(b), .carry_in(cin), .sum(s0), .carry_out(c0));
  lookahead_adder #(.LINK(LINK_RIPPLE_GROUPS)) i_lookahead_adder_rg (
    .a(a), .b(b), .carry_in(cin), .sum(s1), .carry_out(c1));
  lookahead_adder #(.LINK(LINK_RIPPLE_INSIDE)) i_lookahead_adder_ri (
    .a(a), .b(b), .carry_in(cin), .sum(s2), .carry_out(c2));

  // {a, b, carry_in, expected {carry_out, sum}}
  localparam int NVEC = 12;
  localparam logic [49:0] VEC [NVEC] = '{
    {16'h0000, 16'h0000, 1'b0, 17'h0_0000},  // R1 zero
    {16'hFFFF, 16'h0000, 1'b1, 17'h1_0000},  // R2 full propagate
    {16'hFFFF, 16'hFFFF, 1'b0, 17'h1_FFFE},  // R3 both bits set
    {16'hFFFF, 16'hFFFF, 1'b1, 17'h1_FFFF},  // R3 both set plus carry
    {16'h000F, 16'h0001, 1'b0, 17'h0_0010},  // R4 into group 1
    {16'h00FF, 16'h0001, 1'b0, 17'h0_0100},  // R4 into group 2
    {16'h0FFF, 16'h0000, 1'b1, 17'h0_1000},  // R4 into group 3
    {16'h8000, 16'h8000, 1'b0, 17'h1_0000},  // R6 top-bit overflow
    {16'h1234, 16'h4321, 1'b0, 17'h0_5555},  // R1 no carries
    {16'hAAAA, 16'h5555, 1'b1, 17'h1_0000},  // R2 alternating propagate
    {16'h7FFF, 16'h0001, 1'b0, 17'h0_8000},  // R6 no overflow at edge
    {16'hF0F0, 16'h0F0F, 1'b0, 17'h0_FFFF}   // R1 disjoint bits
  };

  task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: a=%h b=%h cin=%b got %h expected %h", req, a, b, cin, act, exp);
    end
  endtask

  task automatic apply_and_check(input string req, input logic [15:0] va,
                                 input logic [15:0] vb, input logic vc,
                                 input logic [16:0] exp);
    @(posedge clk);
    a = va; b = vb; cin = vc;
    @(negedge clk);
    check({req, " two-level"}, {c0, s0}, exp);
    check({"R5 ripple-groups vs ", req}, {c1, s1}, exp);
    check({"R5 ripple-inside vs ", req}, {c2, s2}, exp);
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    @(negedge clk);
    check("R1 idle zero", {c0, s0}, 17'h0);

    for (int i = 0; i < NVEC; i++)
      apply_and_check("R1 table", VEC[i][49:34], VEC[i][33:18], VEC[i][17], VEC[i][16:0]);

    // Directed: carry into each group boundary with carry_in only (R4)
    for (int k = 1; k < 4; k++) begin
      logic [15:0] ones = 16'((32'h1 << (k * 4)) - 1);
      apply_and_check("R4 boundary", ones, 16'h0000, 1'b1, {1'b0, ones} + 17'h1);
    end

    // Random vectors against behavioural sum (R1, R5, R6)
    for (int i = 0; i < 2000; i++) begin
      logic [15:0] ra = 16'($urandom);
      logic [15:0] rb = 16'($urandom);
      logic        rc = 1'($urandom);
      apply_and_check("R1 random", ra, rb, rc, {1'b0, ra} + {1'b0, rb} + {16'h0, rc});
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule